// File: doc/BRIEF.md
# PLL Clock-Valid Startup Sequencer

This block decides when a PLL-derived clock may reach downstream logic. It runs from an always-present free-running clock and watches two power-good pins, one for the main rail and one for the PLL and reference rail. Only when both rails are good does it release system reset and enable the PLL. It then strobes a configuration load and waits for the configuration logic to report completion. After that it requires the raw lock indication to stay high for a programmable run of consecutive cycles before it declares the clock valid and opens the clock gate.

In operation, a source-switchover or frequency-change request withdraws clock-valid and runs configuration and qualification again. A lock loss is counted and triggers an automatic relock, up to a programmable number of attempts. Each bring-up is timed from PLL enable to qualified lock. A bring-up that runs past a programmable limit, or a relock after the attempts are used up, is counted as a clock failure and parks the block in a fail state. The event counters and the last measured lock time are read through a small address/data read port.

Top module: `clkvalid_seq`

## Requirements
- R1: `pll_en` is low whenever the synchronized main-rail or PLL-rail power-good is low. After both pins rise it goes high on the third rising clock edge: two synchronizer stages, then the state register.
- R2: `sys_rst` stays high while either rail is not good, so the main rail being good on its own keeps reset asserted. It falls on the same edge that raises `pll_en`.
- R3: `cfg_load` is a one-cycle strobe issued on the edge after `pll_en` rises. Raw lock is ignored until `cfg_done` is seen high in a configuration cycle, so a lock that is already high during configuration does not raise `clk_valid`.
- R4: In the qualifying state, `clk_valid` rises exactly Q+2 rising edges after the lock pin rises, where Q is `cfg_qual_cycles` (the lock pin must stay high for Q consecutive synchronized cycles).
- R5: `clk_gate_en` is high exactly when `clk_valid` is high. It is never high while `pll_en` is low or `sys_rst` is high.
- R6: A `switch_req` sampled high in the run or qualifying state drives `clk_valid` low on the next edge. On that same edge it issues a new `cfg_load` strobe, and it does not count as a lock loss. `clk_valid` returns only after `cfg_done` and a full new qualification.
- R7: The lock timer counts the cycles in which `pll_en` is high and `clk_valid` is low since the latest (re)start. On qualified lock its value is readable at address 3. If it reaches `cfg_lock_limit` cycles without qualifying, then after limit+1 such cycles the block enters the fail state, sets `lock_time_over`, and increments the fail counter.
- R8: A synchronized lock drop in the run state increments the loss counter (address 0). While the number of attempts since reset is below `cfg_retry_max`, it also increments the relock counter (address 1) and starts a new qualification without reconfiguring.
- R9: A lock drop during qualification clears the qualification count, so a later rise again needs Q full consecutive cycles.
- R10: Loss of either rail's synchronized power-good returns the block to its reset state on the next edge. On that edge `pll_en`, `clk_valid` and `clk_gate_en` fall and `sys_rst` rises together, i.e. on the third edge after the pin falls.
- R11: A lock drop in the run state with no attempts left increments the fail counter (address 2) and enters the fail state. In the fail state `pll_en` and `clk_valid` stay low regardless of lock, until reset or a rail loss.
- R12: The loss, relock and fail counters saturate at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_pg_a | input | 1 | Main-rail power-good, asynchronous |
| pll_pg_a | input | 1 | PLL/reference-rail power-good, asynchronous |
| lock_a | input | 1 | Raw PLL lock, asynchronous |
| cfg_done | input | 1 | Configuration complete, synchronous |
| switch_req | input | 1 | Switchover / frequency-change request, synchronous |
| cfg_qual_cycles | input | QUAL_W | Required consecutive lock cycles |
| cfg_lock_limit | input | LT_W | Lock-time limit in cycles |
| cfg_retry_max | input | RETRY_W | Automatic relock attempts allowed |
| rd_addr | input | 2 | Read select: 0 loss, 1 relock, 2 fail, 3 last lock time |
| rd_data | output | RD_W | Selected value, zero-extended |
| pll_en | output | 1 | PLL enable |
| cfg_load | output | 1 | Configuration-load strobe |
| sys_rst | output | 1 | System reset, active high |
| clk_valid | output | 1 | Qualified clock-valid flag |
| clk_gate_en | output | 1 | Downstream clock-gate enable |
| lock_time_over | output | 1 | Lock-time limit exceeded |

## Verification
Some properties are checked on every cycle: the rail gating of enable and reset, the ordering of the load strobe after enable, the drop of clock-valid after a request, the stickiness of the fail state, the gate never opening without enable, and counters holding at full scale. Other behaviour only the bench scenarios can show: the exact Q+2 edge latency of qualification, a restart after a partial lock run, the lock time read back against a count the bench keeps itself, the limit-triggered failure after exactly limit+1 window cycles, and the counter values through a sweep of thirteen lock losses that first saturates the counters and then exhausts the relock attempts.

// File: rtl/clkvalid_seq_pkg.sv
package clkvalid_seq_pkg;
    typedef enum logic [2:0] {
        ST_RESET,
        ST_ENABLE,
        ST_CONFIG,
        ST_QUALIFY,
        ST_RUN,
        ST_FAIL
    } seq_state_e;

    localparam int EVT_LOSS   = 0;
    localparam int EVT_RELOCK = 1;
    localparam int EVT_FAIL   = 2;
    localparam int NUM_EVT    = 3;
endpackage

// File: rtl/cvs_sync2.sv
module cvs_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d_a[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/cvs_sat_counter.sv
module cvs_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !(&cnt_q)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/cvs_lock_qual.sv
module cvs_lock_qual #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         lock_s,
    input  logic [W-1:0] need_cycles,
    output logic         qualified
);
    logic [W-1:0] run_d, run_q;
    logic [W:0]   seen;

    always_comb begin
        run_d = run_q;
        if (!active || !lock_s) run_d = '0;
        else if (!(&run_q))     run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign seen      = {1'b0, run_q} + 1'b1;
    assign qualified = active && lock_s && (seen >= {1'b0, need_cycles});
endmodule

// File: rtl/clkvalid_seq.sv
module clkvalid_seq
    import clkvalid_seq_pkg::*;
#(
    parameter int QUAL_W  = 16,
    parameter int LT_W    = 20,
    parameter int CNT_W   = 8,
    parameter int RETRY_W = 4,
    localparam int RD_W   = (LT_W > CNT_W) ? LT_W : CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               main_pg_a,
    input  logic               pll_pg_a,
    input  logic               lock_a,
    input  logic               cfg_done,
    input  logic               switch_req,
    input  logic [QUAL_W-1:0]  cfg_qual_cycles,
    input  logic [LT_W-1:0]    cfg_lock_limit,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic [1:0]         rd_addr,
    output logic [RD_W-1:0]    rd_data,
    output logic               pll_en,
    output logic               cfg_load,
    output logic               sys_rst,
    output logic               clk_valid,
    output logic               clk_gate_en,
    output logic               lock_time_over
);
    typedef struct packed {
        seq_state_e         st;
        logic [LT_W-1:0]    lt;
        logic [LT_W-1:0]    last_lt;
        logic [RETRY_W-1:0] retry;
        logic               over;
        logic               load;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [2:0] sync_out;
    logic       main_s, pll_s, lock_s;
    logic       rails_ok, in_window, qual_ok;
    logic [NUM_EVT-1:0]            evt_inc;
    logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt;

    cvs_sync2 #(.W(3)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   ({lock_a, pll_pg_a, main_pg_a}),
        .q     (sync_out)
    );
    assign main_s = sync_out[0];
    assign pll_s  = sync_out[1];
    assign lock_s = sync_out[2];

    cvs_lock_qual #(.W(QUAL_W)) qual_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (r_q.st == ST_QUALIFY),
        .lock_s      (lock_s),
        .need_cycles (cfg_qual_cycles),
        .qualified   (qual_ok)
    );

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        cvs_sat_counter #(.W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt_inc[e]),
            .count (evt_cnt[e])
        );
    end

    assign rails_ok  = main_s && pll_s;
    assign in_window = (r_q.st == ST_ENABLE) || (r_q.st == ST_CONFIG) ||
                       (r_q.st == ST_QUALIFY);

    always_comb begin
        r_d     = r_q;
        r_d.load = 1'b0;
        evt_inc = '0;

        if (in_window && !(&r_q.lt)) r_d.lt = r_q.lt + 1'b1;

        case (r_q.st)
            ST_RESET: begin
                r_d.retry = '0;
                r_d.lt    = '0;
                if (rails_ok) begin
                    r_d.st   = ST_ENABLE;
                    r_d.over = 1'b0;
                end
            end
            ST_ENABLE: begin
                r_d.st   = ST_CONFIG;
                r_d.load = 1'b1;
            end
            ST_CONFIG: begin
                if (cfg_done) r_d.st = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (switch_req) begin
                    r_d.st   = ST_CONFIG;
                    r_d.load = 1'b1;
                    r_d.lt   = '0;
                end else if (qual_ok) begin
                    r_d.st      = ST_RUN;
                    r_d.last_lt = (&r_q.lt) ? r_q.lt : r_q.lt + 1'b1;
                end
            end
            ST_RUN: begin
                if (switch_req) begin
                    r_d.st   = ST_CONFIG;
                    r_d.load = 1'b1;
                    r_d.lt   = '0;
                end else if (!lock_s) begin
                    evt_inc[EVT_LOSS] = 1'b1;
                    if (r_q.retry < cfg_retry_max) begin
                        r_d.retry           = r_q.retry + 1'b1;
                        evt_inc[EVT_RELOCK] = 1'b1;
                        r_d.st              = ST_QUALIFY;
                        r_d.lt              = '0;
                    end else begin
                        evt_inc[EVT_FAIL] = 1'b1;
                        r_d.st            = ST_FAIL;
                    end
                end
            end
            ST_FAIL: begin
                r_d.st = ST_FAIL;
            end
            default: r_d.st = ST_RESET;
        endcase

        if (in_window && (r_q.lt >= cfg_lock_limit) && !(r_q.st == ST_QUALIFY && switch_req)) begin
            r_d.st            = ST_FAIL;
            r_d.over          = 1'b1;
            r_d.load          = 1'b0;
            evt_inc[EVT_FAIL] = 1'b1;
        end

        if (!rails_ok) begin
            r_d.st   = ST_RESET;
            r_d.load = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_RESET;
            r_q.lt      <= '0;
            r_q.last_lt <= '0;
            r_q.retry   <= '0;
            r_q.over    <= 1'b0;
            r_q.load    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pll_en         = in_window || (r_q.st == ST_RUN);
    assign cfg_load       = r_q.load;
    assign sys_rst        = (r_q.st == ST_RESET);
    assign clk_valid      = (r_q.st == ST_RUN);
    assign clk_gate_en    = clk_valid;
    assign lock_time_over = r_q.over;

    always_comb begin
        case (rd_addr)
            2'd0:    rd_data = RD_W'(evt_cnt[EVT_LOSS]);
            2'd1:    rd_data = RD_W'(evt_cnt[EVT_RELOCK]);
            2'd2:    rd_data = RD_W'(evt_cnt[EVT_FAIL]);
            default: rd_data = RD_W'(r_q.last_lt);
        endcase
    end
endmodule

// File: rtl/clkvalid_seq_chk.sv
module clkvalid_seq_chk
    import clkvalid_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   main_s,
    input logic                   pll_s,
    input logic                   lock_s,
    input logic                   switch_req,
    input logic                   pll_en,
    input logic                   cfg_load,
    input logic                   sys_rst,
    input logic                   clk_valid,
    input logic                   clk_gate_en,
    input seq_state_e             st,
    input logic [2:0][CNT_W-1:0]  evt_cnt
);
    // R1
    rails_gate_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_s && pll_s) |=> !pll_en);
    // R2
    hold_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_s && pll_s) |=> sys_rst);
    // R3
    load_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (pll_en && $past(pll_en)));
    // R4
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_valid) |-> $past(lock_s));
    // R5
    gate_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_en |-> (pll_en && !sys_rst));
    // R6
    switch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_req |=> !clk_valid);
    // R10
    rail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_s) |=> (!clk_gate_en && sys_rst));
    // R11
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && main_s && pll_s) |=> (st == ST_FAIL && !pll_en));
    // R12
    loss_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&evt_cnt[EVT_LOSS]) |=> (&evt_cnt[EVT_LOSS]));
    // R12
    relock_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&evt_cnt[EVT_RELOCK]) |=> (&evt_cnt[EVT_RELOCK]));
    // R12
    fail_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&evt_cnt[EVT_FAIL]) |=> (&evt_cnt[EVT_FAIL]));
endmodule

bind clkvalid_seq clkvalid_seq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_s      (main_s),
    .pll_s       (pll_s),
    .lock_s      (lock_s),
    .switch_req  (switch_req),
    .pll_en      (pll_en),
    .cfg_load    (cfg_load),
    .sys_rst     (sys_rst),
    .clk_valid   (clk_valid),
    .clk_gate_en (clk_gate_en),
    .st          (r_q.st),
    .evt_cnt     (evt_cnt)
);

// File: tb/clkvalid_seq_tb_top.sv
module clkvalid_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QW = 8;
    localparam int LW = 10;
    localparam int CW = 3;
    localparam int RW = 4;
    localparam int DW = (LW > CW) ? LW : CW;
    localparam int Q  = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_pg_a = 1'b0, pll_pg_a = 1'b0, lock_a = 1'b0;
    logic cfg_done = 1'b0, switch_req = 1'b0;
    logic [QW-1:0] cfg_qual_cycles = QW'(Q);
    logic [LW-1:0] cfg_lock_limit = LW'(200);
    logic [RW-1:0] cfg_retry_max = RW'(12);
    logic [1:0] rd_addr = 2'd0;
    logic [DW-1:0] rd_data;
    logic pll_en, cfg_load, sys_rst, clk_valid, clk_gate_en, lock_time_over;

    int checks = 0;
    int fails = 0;
    int win_cnt = 0;
    int last_win = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkvalid_seq #(.QUAL_W(QW), .LT_W(LW), .CNT_W(CW), .RETRY_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .main_pg_a(main_pg_a), .pll_pg_a(pll_pg_a),
        .lock_a(lock_a), .cfg_done(cfg_done), .switch_req(switch_req),
        .cfg_qual_cycles(cfg_qual_cycles), .cfg_lock_limit(cfg_lock_limit),
        .cfg_retry_max(cfg_retry_max), .rd_addr(rd_addr), .rd_data(rd_data),
        .pll_en(pll_en), .cfg_load(cfg_load), .sys_rst(sys_rst),
        .clk_valid(clk_valid), .clk_gate_en(clk_gate_en),
        .lock_time_over(lock_time_over)
    );

    // Window monitor: counts cycles with enable high and clock not yet valid.
    always @(posedge clk) begin
        if (pll_en && !clk_valid) win_cnt <= win_cnt + 1;
        else begin
            if (clk_valid && win_cnt != 0) last_win <= win_cnt;
            win_cnt <= 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic int smin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        int hi;
        @(negedge clk);
        edges(3);
        chk("R2 reset sys_rst", sys_rst, 1);
        chk("R1 reset pll_en", pll_en, 0);
        chk("R5 reset gate", clk_gate_en, 0);
        rst_n = 1'b1;
        edges(1);

        // Main rail alone must not release reset.
        main_pg_a = 1'b1;
        edges(10);
        chk("R2 main only sys_rst", sys_rst, 1);
        chk("R1 main only pll_en", pll_en, 0);

        pll_pg_a = 1'b1;
        edges(2);
        chk("R1 en after 2 edges", pll_en, 0);
        edges(1);
        chk("R1 en after 3 edges", pll_en, 1);
        chk("R2 reset released", sys_rst, 0);
        edges(1);
        chk("R3 load strobe", cfg_load, 1);
        edges(1);
        chk("R3 load one cycle", cfg_load, 0);

        // Lock during configuration is ignored.
        lock_a = 1'b1;
        edges(20);
        chk("R3 no valid before cfg_done", clk_valid, 0);
        lock_a = 1'b0;
        edges(3);
        cfg_done = 1'b1;
        edges(1);
        cfg_done = 1'b0;

        lock_a = 1'b1;
        edges(Q + 1);
        chk("R4 not valid at Q+1", clk_valid, 0);
        edges(1);
        chk("R4 valid at Q+2", clk_valid, 1);
        chk("R5 gate follows", clk_gate_en, 1);
        edges(1);
        rd(2'd3, v);
        chk("R7 lock time read", v, last_win);
        chk("R7 lock time span", v, 1 + 1 + 20 + 3 + 1 + Q + 2);

        // Switchover.
        switch_req = 1'b1;
        edges(1);
        switch_req = 1'b0;
        chk("R6 valid drops", clk_valid, 0);
        chk("R5 gate drops", clk_gate_en, 0);
        chk("R6 reload strobe", cfg_load, 1);
        lock_a = 1'b0;
        edges(4);
        cfg_done = 1'b1;
        edges(1);
        cfg_done = 1'b0;
        lock_a = 1'b1;
        edges(Q - 1);
        lock_a = 1'b0;
        edges(3);
        chk("R9 short run no valid", clk_valid, 0);
        lock_a = 1'b1;
        edges(Q + 1);
        chk("R9 restart not valid at Q+1", clk_valid, 0);
        edges(1);
        chk("R9 restart valid at Q+2", clk_valid, 1);
        rd(2'd0, v);
        chk("R6 switch not a loss", v, 0);

        // Lock-loss sweep: saturate counters, then exhaust attempts.
        for (int k = 1; k <= 13; k++) begin
            lock_a = 1'b0;
            edges(2);
            chk("R8 valid before loss seen", clk_valid, 1);
            edges(1);
            chk("R8 valid dropped", clk_valid, 0);
            rd(2'd0, v);
            chk("R12 loss count", v, smin(k, CMAX));
            rd(2'd1, v);
            chk("R12 relock count", v, smin(smin(k, 12), CMAX));
            rd(2'd2, v);
            chk("R11 fail count", v, (k == 13) ? 1 : 0);
            if (k < 13) begin
                lock_a = 1'b1;
                edges(Q + 2);
                chk("R8 relocked", clk_valid, 1);
            end
        end
        chk("R11 pll_en low in fail", pll_en, 0);
        lock_a = 1'b1;
        edges(20);
        chk("R11 stays failed valid", clk_valid, 0);
        chk("R11 stays failed en", pll_en, 0);

        // Rail loss from fail, then bring up again.
        pll_pg_a = 1'b0;
        edges(3);
        chk("R10 reset after rail loss", sys_rst, 1);
        pll_pg_a = 1'b1;
        edges(3);
        chk("R1 re-enable", pll_en, 1);
        edges(1);
        cfg_done = 1'b1;
        edges(1);
        cfg_done = 1'b0;
        edges(Q + 1);
        chk("R4 valid after rebring", clk_valid, 1);
        main_pg_a = 1'b0;
        edges(2);
        chk("R10 valid before sync", clk_valid, 1);
        edges(1);
        chk("R10 valid low", clk_valid, 0);
        chk("R10 en low", pll_en, 0);
        chk("R10 gate low", clk_gate_en, 0);
        chk("R10 sys_rst high", sys_rst, 1);

        // Lock-time limit overrun.
        cfg_lock_limit = LW'(20);
        lock_a = 1'b0;
        edges(2);
        main_pg_a = 1'b1;
        edges(3);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            if (pll_en) hi++;
            cfg_done = (i == 1);
            edges(1);
        end
        cfg_done = 1'b0;
        chk("R7 window length at limit", hi, 21);
        chk("R7 over flag", lock_time_over, 1);
        rd(2'd2, v);
        chk("R7 fail count", v, 2);
        chk("R7 en low after overrun", pll_en, 0);

        finish_run();
    end
endmodule